// File: doc/BRIEF.md
# Packed Decimal Field Adder

This unit adds two signed packed-decimal fields and returns the sum in the shape of the first field. Each field is 1 to 16 bytes long, and each operand has its own length. Every byte carries two BCD digits, except the least significant byte, which carries one digit in its upper nibble and the sign code in its lower nibble. A caller puts both fields on the inputs, right-aligned, together with their byte lengths, and pulses `start`. The unit then works one digit per cycle, from the least significant digit upward.

When the two signs agree, the magnitudes are added with a decimal carry. When they differ, the second magnitude is subtracted from the first. If that subtraction borrows out of the top digit, a second pass takes the ten's complement of the partial result and inverts the result sign. At the end the unit checks for overflow past the first field's digit count and packs the result. It reports a two-bit condition code and flags for a data exception and for decimal overflow.

Top module: `pdec_adder`

## Requirements
- R1: Fields are right-aligned on the inputs. Nibble 0 (bits 3:0) is the sign code, and nibble k (k ≥ 1) is decimal digit k-1, counted from the right. A length of L bytes covers nibbles 0 to 2L-1. Input bits above a field's length are ignored, and result bits above `len_a` bytes are zero.
- R2: With like signs the magnitudes are added, and the decimal carry moves from each digit into the next. Digits of the second field beyond its length count as zero.
- R3: With unlike signs the result magnitude is |A| − |B|, carrying the sign of A. When |B| > |A| the magnitude is |B| − |A| and the result takes the inverted sign of A.
- R4: Sign codes A, C, E and F mean positive, and B and D mean negative. A positive result is written with sign C and a negative result with sign D.
- R5: A result whose digits are all zero is written with sign C, whatever the operand signs.
- R6: When there is no exception, the condition code is 0 for a zero result, 1 for a negative result, 2 for a positive result, and 3 on overflow.
- R7: If the true sum has a nonzero digit at or above digit position 2·`len_a`−1, `dec_ovf` is set and the condition code is 3. The result then holds the low digits of the sum, truncated.
- R8: A digit nibble above 9 inside a field's length, or a sign nibble below A in either field, sets `data_exc`. In that case the result equals the first field within `len_a`, `dec_ovf` is 0 and the condition code is 0.
- R9: A `start` pulse while the unit is idle captures all inputs. `busy` then stays high until `done` pulses for exactly one cycle. The outputs hold their values until the next `done`. A `start` pulse while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `result`, `cc`, `data_exc` and `dec_ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an addition (taken only when idle) |
| len_a | input | 5 | First field length in bytes, 1 to 16 |
| len_b | input | 5 | Second field length in bytes, 1 to 16 |
| field_a | input | 128 | First field, right-aligned, sign in bits 3:0 |
| field_b | input | 128 | Second field, right-aligned, sign in bits 3:0 |
| busy | output | 1 | Addition in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | 128 | Sum in the first field's format |
| cc | output | 2 | Condition code |
| data_exc | output | 1 | Invalid digit or sign found |
| dec_ovf | output | 1 | Sum did not fit the first field |

## Verification
The bench drives a carry that ripples through a run of nines, a second field shorter than the first, and a second field longer than the first. It also drives an unlike-sign subtraction that borrows out, where a design without the re-complement pass would return a nines-complement value with the wrong sign. A negative zero is included, to catch a design that keeps sign D. An unlike-sign overflow case covers the long-second-field situation, where a design that looked only at the carry would miss the overflow. Further cases cover junk above the stated lengths, a bad digit, a bad sign, 16-byte fields at both extremes, and a `start` pulse issued in the middle of an operation. Each of these would show up as a wrong result field, condition code or flag, or as an extra `done`.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ADD,
        ST_RECOMP,
        ST_FIN
    } pdec_state_e;

    localparam logic [3:0] SIGN_PLUS  = 4'hC;
    localparam logic [3:0] SIGN_MINUS = 4'hD;

    function automatic logic sign_is_minus(input logic [3:0] s);
        return (s == 4'hB) || (s == 4'hD);
    endfunction

endpackage

// File: rtl/pdec_field_check.sv
module pdec_field_check
    import pdec_pkg::*;
#(
    parameter int MAX_BYTES = 16,
    parameter int LEN_W     = 5
) (
    input  logic [8*MAX_BYTES-1:0] field,
    input  logic [LEN_W-1:0]       len,
    output logic                   ok,
    output logic                   minus
);
    localparam int NNIB = 2 * MAX_BYTES;

    always_comb begin
        ok = (field[3:0] >= 4'hA);
        for (int k = 1; k < NNIB; k++) begin
            if ((k < 2 * int'(len)) && (field[4*k +: 4] > 4'd9)) begin
                ok = 1'b0;
            end
        end
        minus = sign_is_minus(field[3:0]);
    end

endmodule

// File: rtl/pdec_digit_alu.sv
module pdec_digit_alu (
    input  logic [3:0] x,
    input  logic [3:0] y,
    input  logic       cin,
    input  logic       sub,
    output logic [3:0] r,
    output logic       cout
);
    logic [4:0] t;

    always_comb begin
        cout = 1'b0;
        if (!sub) begin
            t = 5'(x) + 5'(y) + 5'(cin);
            r = t[3:0];
            if (t > 5'd9) begin
                r    = 4'(t - 5'd10);
                cout = 1'b1;
            end
        end else begin
            t = 5'(x) - 5'(y) - 5'(cin);
            r = t[3:0];
            if (t[4]) begin
                r    = 4'(t + 5'd10);
                cout = 1'b1;
            end
        end
        AST_DIGIT_RANGE: assert ((x > 4'd9) || (y > 4'd9) || (r <= 4'd9)); // R2
    end

endmodule

// File: rtl/pdec_adder.sv
module pdec_adder
    import pdec_pkg::*;
#(
    parameter int MAX_BYTES = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [$clog2(MAX_BYTES+1)-1:0]       len_a,
    input  logic [$clog2(MAX_BYTES+1)-1:0]       len_b,
    input  logic [8*MAX_BYTES-1:0]               field_a,
    input  logic [8*MAX_BYTES-1:0]               field_b,
    output logic                                 busy,
    output logic                                 done,
    output logic [8*MAX_BYTES-1:0]               result,
    output logic [1:0]                           cc,
    output logic                                 data_exc,
    output logic                                 dec_ovf
);
    localparam int FW    = 8 * MAX_BYTES;
    localparam int NDIG  = 2 * MAX_BYTES - 1;
    localparam int LEN_W = $clog2(MAX_BYTES + 1);
    localparam int IDX_W = $clog2(NDIG + 1);

    typedef struct packed {
        pdec_state_e       st;
        logic [FW-1:0]     a;
        logic [FW-1:0]     b;
        logic [LEN_W-1:0]  la;
        logic [LEN_W-1:0]  lb;
        logic [NDIG*4-1:0] work;
        logic [IDX_W-1:0]  idx;
        logic              cy;
        logic              sub;
        logic              flip;
        logic              a_minus;
        logic              busy;
        logic              done;
        logic [FW-1:0]     res;
        logic [1:0]        cc;
        logic              exc;
        logic              ovf;
    } pdec_regs_t;

    pdec_regs_t q, d;

    // Operand validation, one checker per field
    logic [FW-1:0]    op_field [2];
    logic [LEN_W-1:0] op_len   [2];
    logic             op_ok    [2];
    logic             op_minus [2];

    assign op_field[0] = q.a;
    assign op_field[1] = q.b;
    assign op_len[0]   = q.la;
    assign op_len[1]   = q.lb;

    for (genvar g = 0; g < 2; g++) begin : g_chk
        pdec_field_check #(
            .MAX_BYTES(MAX_BYTES),
            .LEN_W    (LEN_W)
        ) u_chk (
            .field(op_field[g]),
            .len  (op_len[g]),
            .ok   (op_ok[g]),
            .minus(op_minus[g])
        );
    end

    // One-digit arithmetic
    logic [3:0] alu_x, alu_y, alu_r;
    logic       alu_sub, alu_co;

    pdec_digit_alu u_alu (
        .x   (alu_x),
        .y   (alu_y),
        .cin (q.cy),
        .sub (alu_sub),
        .r   (alu_r),
        .cout(alu_co)
    );

    int            n_a, n_b, n_d, widx;
    logic [FW-1:0] a_sh, b_sh;
    logic [NDIG*4-1:0] w_sh;
    logic          res_zero, res_minus, hi_nonzero;
    logic [FW-1:0] packed_res, masked_a;

    always_comb begin
        n_a  = 2 * int'(q.la) - 1;
        n_b  = 2 * int'(q.lb) - 1;
        n_d  = (n_a > n_b) ? n_a : n_b;
        widx = 4 * int'(q.idx);

        a_sh = q.a >> (widx + 4);
        b_sh = q.b >> (widx + 4);
        w_sh = q.work >> widx;

        if (q.st == ST_RECOMP) begin
            alu_x   = 4'd0;
            alu_y   = w_sh[3:0];
            alu_sub = 1'b1;
        end else begin
            alu_x   = (int'(q.idx) < n_a) ? a_sh[3:0] : 4'd0;
            alu_y   = (int'(q.idx) < n_b) ? b_sh[3:0] : 4'd0;
            alu_sub = q.sub;
        end

        // Result evaluation from the working digits
        res_zero   = 1'b1;
        hi_nonzero = 1'b0;
        packed_res = '0;
        for (int k = 0; k < NDIG; k++) begin
            if (k < n_a) begin
                packed_res[4*k+4 +: 4] = q.work[4*k +: 4];
                if (q.work[4*k +: 4] != 4'd0) res_zero = 1'b0;
            end else if (q.work[4*k +: 4] != 4'd0) begin
                hi_nonzero = 1'b1;
            end
        end
        res_minus = (q.a_minus ^ q.flip) && !res_zero;
        packed_res[3:0] = res_minus ? SIGN_MINUS : SIGN_PLUS;

        masked_a = '0;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (i < int'(q.la)) masked_a[8*i +: 8] = q.a[8*i +: 8];
        end

        d      = q;
        d.done = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.a    = field_a;
                    d.b    = field_b;
                    d.la   = len_a;
                    d.lb   = len_b;
                    d.busy = 1'b1;
                    d.st   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (!op_ok[0] || !op_ok[1]) begin
                    d.res  = masked_a;
                    d.exc  = 1'b1;
                    d.ovf  = 1'b0;
                    d.cc   = 2'd0;
                    d.done = 1'b1;
                    d.busy = 1'b0;
                    d.st   = ST_IDLE;
                end else begin
                    d.sub     = op_minus[0] ^ op_minus[1];
                    d.a_minus = op_minus[0];
                    d.flip    = 1'b0;
                    d.work    = '0;
                    d.idx     = '0;
                    d.cy      = 1'b0;
                    d.st      = ST_ADD;
                end
            end
            ST_ADD: begin
                d.work[widx +: 4] = alu_r;
                d.cy              = alu_co;
                if (int'(q.idx) == n_d - 1) begin
                    d.idx = '0;
                    if (q.sub && alu_co) begin
                        d.cy   = 1'b0;
                        d.flip = 1'b1;
                        d.st   = ST_RECOMP;
                    end else begin
                        d.st = ST_FIN;
                    end
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_RECOMP: begin
                d.work[widx +: 4] = alu_r;
                d.cy              = alu_co;
                if (int'(q.idx) == n_d - 1) begin
                    d.st = ST_FIN;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_FIN: begin
                d.res  = packed_res;
                d.exc  = 1'b0;
                d.ovf  = hi_nonzero || (!q.sub && q.cy);
                if (hi_nonzero || (!q.sub && q.cy)) d.cc = 2'd3;
                else if (res_zero)                  d.cc = 2'd0;
                else if (res_minus)                 d.cc = 2'd1;
                else                                d.cc = 2'd2;
                d.done = 1'b1;
                d.busy = 1'b0;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign result   = q.res;
    assign cc       = q.cc;
    assign data_exc = q.exc;
    assign dec_ovf  = q.ovf;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R9
    AST_OVF_CODE3: assert property (@(posedge clk) disable iff (!rst_n) (done && dec_ovf) |-> (cc == 2'd3)); // R7
    AST_EXC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (done && data_exc) |-> (!dec_ovf && cc == 2'd0)); // R8
    AST_ZERO_SIGN_C: assert property (@(posedge clk) disable iff (!rst_n) (done && !data_exc && cc == 2'd0) |-> (result[3:0] == 4'hC)); // R5

endmodule

// File: tb/pdec_adder_tb.sv
module pdec_adder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MB = 16;
    localparam int FW = 8 * MB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [4:0]    len_a = '0, len_b = '0;
    logic [FW-1:0] field_a = '0, field_b = '0;
    logic          busy, done, data_exc, dec_ovf;
    logic [FW-1:0] result;
    logic [1:0]    cc;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [FW-1:0] res;
        logic [1:0]    cc;
        logic          exc;
        logic          ovf;
        string         tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pdec_adder #(.MAX_BYTES(MB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .len_a(len_a), .len_b(len_b),
        .field_a(field_a), .field_b(field_b),
        .busy(busy), .done(done), .result(result),
        .cc(cc), .data_exc(data_exc), .dec_ovf(dec_ovf)
    );

    // Reference: magnitude compare, then larger minus smaller
    function automatic exp_t model(logic [FW-1:0] a, logic [FW-1:0] b, int la, int lb, string tag);
        exp_t e;
        int da[32], db[32], rd[32];
        int na, nb, c, t;
        logic ok, am, bm, rm, zero, a_ge;
        na = 2 * la - 1;
        nb = 2 * lb - 1;
        e.tag = tag;
        ok = (a[3:0] >= 4'hA) && (b[3:0] >= 4'hA);
        for (int k = 0; k < 32; k++) begin
            da[k] = 0; db[k] = 0; rd[k] = 0;
        end
        for (int k = 0; k < na; k++) begin
            da[k] = int'(a[4*k+4 +: 4]);
            if (da[k] > 9) ok = 1'b0;
        end
        for (int k = 0; k < nb; k++) begin
            db[k] = int'(b[4*k+4 +: 4]);
            if (db[k] > 9) ok = 1'b0;
        end
        if (!ok) begin
            e.res = '0;
            for (int i = 0; i < la; i++) e.res[8*i +: 8] = a[8*i +: 8];
            e.cc = 2'd0; e.exc = 1'b1; e.ovf = 1'b0;
            return e;
        end
        am = (a[3:0] == 4'hB) || (a[3:0] == 4'hD);
        bm = (b[3:0] == 4'hB) || (b[3:0] == 4'hD);
        if (am == bm) begin
            c = 0;
            for (int k = 0; k < 32; k++) begin
                t = da[k] + db[k] + c;
                rd[k] = t % 10;
                c = t / 10;
            end
            rm = am;
        end else begin
            a_ge = 1'b1;
            for (int k = 31; k >= 0; k--) begin
                if (da[k] != db[k]) begin
                    a_ge = (da[k] > db[k]);
                    break;
                end
            end
            c = 0;
            for (int k = 0; k < 32; k++) begin
                t = a_ge ? (da[k] - db[k] - c) : (db[k] - da[k] - c);
                c = (t < 0) ? 1 : 0;
                rd[k] = (t < 0) ? t + 10 : t;
            end
            rm = a_ge ? am : !am;
        end
        e.ovf = 1'b0;
        zero = 1'b1;
        e.res = '0;
        for (int k = 0; k < 32; k++) begin
            if (k < na) begin
                e.res[4*k+4 +: 4] = 4'(rd[k]);
                if (rd[k] != 0) zero = 1'b0;
            end else if (rd[k] != 0) begin
                e.ovf = 1'b1;
            end
        end
        rm = rm && !zero;
        e.res[3:0] = rm ? 4'hD : 4'hC;
        e.exc = 1'b0;
        e.cc  = e.ovf ? 2'd3 : zero ? 2'd0 : rm ? 2'd1 : 2'd2;
        return e;
    endfunction

    task automatic pulse_start(logic [FW-1:0] a, logic [FW-1:0] b, int la, int lb);
        @(negedge clk);
        field_a = a; field_b = b;
        len_a = 5'(la); len_b = 5'(lb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(logic [FW-1:0] a, logic [FW-1:0] b, int la, int lb, string tag);
        exp_q.push_back(model(a, b, la, lb, tag));
        pulse_start(a, b, la, lb);
        do @(negedge clk); while (!done);
    endtask

    task automatic check(logic ok, string tag, logic [FW-1:0] act, logic [FW-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected done", FW'(1), FW'(0));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(result == e.res, {e.tag, " result"}, result, e.res);
                check(cc == e.cc, {e.tag, " cc"}, FW'(cc), FW'(e.cc));
                check(data_exc == e.exc, {e.tag, " data_exc"}, FW'(data_exc), FW'(e.exc));
                check(dec_ovf == e.ovf, {e.tag, " dec_ovf"}, FW'(dec_ovf), FW'(e.ovf));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({busy, done, data_exc, dec_ovf} == 4'b0, "R10 reset flags",
              FW'({busy, done, data_exc, dec_ovf}), FW'(0));
        check(result == '0 && cc == 2'd0, "R10 reset result", result, FW'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run(FW'(24'h00005F), FW'(8'h1C), 3, 1, "R4 F sign to C");
        run(FW'(48'h05566777788C), FW'(24'h11111D), 6, 3, "R3 unlike no borrow");
        run(FW'(24'h01999F), FW'(16'h020C), 3, 2, "R2 carry ripple short b");
        run(FW'(16'h452C), FW'(16'h452C), 2, 2, "R2 self add");
        run(FW'(16'h123C), FW'(16'h456D), 2, 2, "R3 borrow recomplement");
        run(FW'(8'h7B), FW'(8'h2A), 1, 1, "R4 B and A codes");
        run(FW'(8'h5C), FW'(8'h5D), 1, 1, "R5 unlike zero");
        run(FW'(8'h0D), FW'(8'h0D), 1, 1, "R5 negative zero");
        run(FW'(8'h9C), FW'(8'h1C), 1, 1, "R7 carry overflow");
        run(FW'(8'h1C), FW'(16'h100C), 1, 2, "R7 long b overflow");
        run(FW'(8'h5C), FW'(16'h123D), 1, 2, "R7 unlike long b overflow");
        run(FW'(16'h1A2C), FW'(8'h1C), 2, 1, "R8 bad digit");
        run(FW'(16'h1233), FW'(8'h1C), 2, 1, "R8 bad sign");
        run({64'hDEAD_0000_0000_0000, 64'h0000_0000_0000_123C}, {124'h0, 4'hC} | FW'(8'h1C), 2, 1,
            "R1 junk above length");
        run({{31{4'h9}}, 4'hC}, FW'(8'h1C), 16, 1, "R7 max field overflow");
        run({4'h0, 4'h1, {29{4'h0}}, 4'hC}, FW'(8'h1D), 16, 1, "R3 max field unlike");
        run({{30{4'h1}}, 8'h2D}, {{30{4'h1}}, 8'h1D}, 16, 16, "R6 max both negative");

        // R9: a start pulse in the middle of an operation is ignored
        exp_q.push_back(model(FW'(16'h321C), FW'(16'h111C), 2, 2, "R9 start while busy"));
        pulse_start(FW'(16'h321C), FW'(16'h111C), 2, 2);
        @(negedge clk);
        field_a = FW'(16'h999D); field_b = FW'(16'h888D);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        do @(negedge clk); while (!done);
        repeat (12) @(negedge clk);
        check(!busy && exp_q.size() == 0, "R9 no second run", FW'(busy), FW'(0));
        check(result == FW'(16'h432C), "R9 output held", result, FW'(16'h432C));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule